// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block holds a 24-hour clock and calendar as seven packed-BCD bytes: seconds, minutes, hours, weekday, day of month, month and a two-digit year. Each cycle with the one-second clock-enable `tick_en` high advances the time by one second. Carries ripple through all fields within that same tick, so the outputs never show a part-updated value.

A parallel load replaces all seven fields at once, and counting resumes from the loaded values. A `halt` input freezes counting. The block fixes month lengths by itself. It treats every year divisible by four as a leap year, which is correct for two-digit years up to 2100. Weekday runs 01 to 07 independently of the date.

Each cycle an action is chosen from three named actions, and the state register carries out that action. ACT_LOAD is chosen when `load` is high. ACT_TICK is chosen when `tick_en` is high and `halt` is low. ACT_HOLD covers every other case. ACT_LOAD leads to the load transition, ACT_TICK to the advance transition and ACT_HOLD to the hold transition.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds count 0x00 to 0x59 in BCD. Going past 0x59 gives 0x00 and advances minutes in the same tick.
- R2: Minutes count 0x00 to 0x59 and hours count 0x00 to 0x23. Each wrap advances the next field in the same tick.
- R3: Weekday counts 0x01 to 0x07, advances when hours wrap, and wraps from 0x07 to 0x01 regardless of the date.
- R4: The day of month wraps to 0x01 after the month's last day, and the month then advances. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11, and 0x31 for every other month except 0x02.
- R5: February ends on 0x29 when the BCD year value is divisible by four, with 0x00 counting as divisible. In all other years it ends on 0x28.
- R6: Month wraps from 0x12 to 0x01 and advances the year. The year wraps from 0x99 to 0x00.
- R7: While `halt` is 1, a tick changes no field.
- R8: When `load` is 1, all fields take the load inputs on the next edge. This holds whether or not a tick or `halt` is present, and later ticks count on from the loaded values.
- R9: A tick shows on the outputs one cycle after it is applied. With no tick and no load, the outputs stay unchanged.
- R10: Reset gives 00:00:00, weekday 0x01, date 0x01, month 0x01 and year 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-second advance enable |
| halt | input | 1 | 1 stops counting |
| load | input | 1 | Parallel load strobe |
| ld_sec | input | 8 | Load value, seconds |
| ld_min | input | 8 | Load value, minutes |
| ld_hour | input | 8 | Load value, hours |
| ld_wday | input | 8 | Load value, weekday |
| ld_date | input | 8 | Load value, day of month |
| ld_mon | input | 8 | Load value, month |
| ld_year | input | 8 | Load value, year |
| tm_sec | output | 8 | Seconds |
| tm_min | output | 8 | Minutes |
| tm_hour | output | 8 | Hours |
| tm_wday | output | 8 | Weekday |
| tm_date | output | 8 | Day of month |
| tm_mon | output | 8 | Month |
| tm_year | output | 8 | Year |

## Verification
The bench targets the tick that crosses midnight and every field above it. A design that broke the ripple would show the minute advanced but the hour stale, and a wrong weekday wrap would show 0x08 or 0x00. Month ends are tested for 30-day months, 31-day months, and February in leap years, year 00 and common years. A wrong month table or leap rule would show a 0x31 date or an early roll into March. Load is applied together with a tick and under halt, where a design with the wrong priority would show the loaded value advanced by one second or no load at all.

// File: rtl/cal_pkg.sv
package cal_pkg;
    typedef logic [7:0] bcd_t;

    localparam int NFIELD = 7;

    typedef struct packed {
        bcd_t sec;
        bcd_t min;
        bcd_t hour;
        bcd_t wday;
        bcd_t date;
        bcd_t mon;
        bcd_t year;
    } cal_t;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_TICK = 2'd1,
        ACT_LOAD = 2'd2
    } act_e;
endpackage

// File: rtl/bcd_step.sv
module bcd_step
    import cal_pkg::*;
(
    input  logic en,
    input  bcd_t val,
    input  bcd_t lo,
    input  bcd_t hi,
    output bcd_t nxt,
    output logic wrap
);
    always_comb begin
        nxt  = val;
        wrap = 1'b0;
        if (en) begin
            if (val == hi) begin
                nxt  = lo;
                wrap = 1'b1;
            end else if (val[3:0] == 4'h9) begin
                nxt = {val[7:4] + 4'd1, 4'h0};
            end else begin
                nxt = {val[7:4], val[3:0] + 4'd1};
            end
        end
    end
endmodule

// File: rtl/month_length.sv
module month_length
    import cal_pkg::*;
(
    input  bcd_t mon,
    input  bcd_t year,
    output bcd_t last_day
);
    logic [1:0] mod4;
    logic       leap;

    // (10*tens + ones) mod 4 == (2*tens[0] + ones[1:0]) mod 4
    assign mod4 = {year[4], 1'b0} + year[1:0];
    assign leap = (mod4 == 2'd0);

    always_comb begin
        unique case (mon)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic       halt,
    input  logic       load,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic [7:0] ld_wday,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_mon,
    input  logic [7:0] ld_year,
    output logic [7:0] tm_sec,
    output logic [7:0] tm_min,
    output logic [7:0] tm_hour,
    output logic [7:0] tm_wday,
    output logic [7:0] tm_date,
    output logic [7:0] tm_mon,
    output logic [7:0] tm_year
);
    localparam cal_t RESET_CAL = '{sec: 8'h00, min: 8'h00, hour: 8'h00,
                                   wday: 8'h01, date: 8'h01, mon: 8'h01,
                                   year: 8'h00};

    cal_t cal_q, cal_adv, ld_cal;
    act_e act;
    bcd_t month_end;

    // field index: 0 sec, 1 min, 2 hour, 3 wday, 4 date, 5 mon, 6 year
    bcd_t cur  [NFIELD];
    bcd_t nxt  [NFIELD];
    bcd_t lo   [NFIELD];
    bcd_t hi   [NFIELD];
    logic en   [NFIELD];
    logic wrap [NFIELD];

    assign ld_cal = '{sec: ld_sec, min: ld_min, hour: ld_hour, wday: ld_wday,
                      date: ld_date, mon: ld_mon, year: ld_year};

    month_length u_mlen (
        .mon      (cal_q.mon),
        .year     (cal_q.year),
        .last_day (month_end)
    );

    always_comb begin
        cur[0] = cal_q.sec;  lo[0] = 8'h00; hi[0] = 8'h59;
        cur[1] = cal_q.min;  lo[1] = 8'h00; hi[1] = 8'h59;
        cur[2] = cal_q.hour; lo[2] = 8'h00; hi[2] = 8'h23;
        cur[3] = cal_q.wday; lo[3] = 8'h01; hi[3] = 8'h07;
        cur[4] = cal_q.date; lo[4] = 8'h01; hi[4] = month_end;
        cur[5] = cal_q.mon;  lo[5] = 8'h01; hi[5] = 8'h12;
        cur[6] = cal_q.year; lo[6] = 8'h00; hi[6] = 8'h99;
        en[0] = 1'b1;
        en[1] = wrap[0];
        en[2] = wrap[1];
        en[3] = wrap[2];
        en[4] = wrap[2];
        en[5] = wrap[4];
        en[6] = wrap[5];
    end

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        bcd_step u_step (
            .en   (en[i]),
            .val  (cur[i]),
            .lo   (lo[i]),
            .hi   (hi[i]),
            .nxt  (nxt[i]),
            .wrap (wrap[i])
        );
    end

    assign cal_adv = '{sec: nxt[0], min: nxt[1], hour: nxt[2], wday: nxt[3],
                       date: nxt[4], mon: nxt[5], year: nxt[6]};

    // action select: load beats tick, halt gates tick only
    always_comb begin
        if (load)                 act = ACT_LOAD;
        else if (tick_en && !halt) act = ACT_TICK;
        else                      act = ACT_HOLD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q <= RESET_CAL;
        end else begin
            unique case (act)
                ACT_LOAD: cal_q <= ld_cal;
                ACT_TICK: cal_q <= cal_adv;
                ACT_HOLD: cal_q <= cal_q;
                default:  cal_q <= cal_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        tm_sec  = cal_q.sec;
        tm_min  = cal_q.min;
        tm_hour = cal_q.hour;
        tm_wday = cal_q.wday;
        tm_date = cal_q.date;
        tm_mon  = cal_q.mon;
        tm_year = cal_q.year;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> ({tm_sec, tm_min, tm_hour, tm_wday, tm_date, tm_mon, tm_year} ==
                  $past({ld_sec, ld_min, ld_hour, ld_wday, ld_date, ld_mon, ld_year}))); // R8

    AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && (halt || !tick_en)) |=>
            $stable({tm_sec, tm_min, tm_hour, tm_wday, tm_date, tm_mon, tm_year})); // R7

    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick_en && !halt && tm_sec == 8'h59) |=>
            (tm_sec == 8'h00 && tm_min != $past(tm_min))); // R1

    AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick_en && !halt && tm_sec == 8'h59 && tm_min == 8'h59 &&
         tm_hour == 8'h23 && tm_wday == 8'h07) |=> (tm_wday == 8'h01)); // R3

    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && tick_en && !halt && tm_sec == 8'h59 && tm_min == 8'h59 &&
         tm_hour == 8'h23 && tm_date == 8'h31 && tm_mon == 8'h12 &&
         tm_year == 8'h99) |=> (tm_year == 8'h00 && tm_mon == 8'h01)); // R6
endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       halt = 1'b0;
    logic       load = 1'b0;
    logic [55:0] ld_v = '0;
    logic [7:0] tm_sec, tm_min, tm_hour, tm_wday, tm_date, tm_mon, tm_year;
    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    bcd_calendar dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .halt(halt), .load(load),
        .ld_sec(ld_v[55:48]), .ld_min(ld_v[47:40]), .ld_hour(ld_v[39:32]),
        .ld_wday(ld_v[31:24]), .ld_date(ld_v[23:16]), .ld_mon(ld_v[15:8]),
        .ld_year(ld_v[7:0]),
        .tm_sec(tm_sec), .tm_min(tm_min), .tm_hour(tm_hour), .tm_wday(tm_wday),
        .tm_date(tm_date), .tm_mon(tm_mon), .tm_year(tm_year)
    );

    // packed order: sec min hour wday date mon year
    function automatic logic [55:0] now();
        return {tm_sec, tm_min, tm_hour, tm_wday, tm_date, tm_mon, tm_year};
    endfunction

    task automatic check(input string tag, input logic [55:0] exp);
        n_chk++;
        if (now() !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, now(), exp);
        end
    endtask

    task automatic do_load(input logic [55:0] v);
        @(negedge clk);
        ld_v = v; load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic tick_once();
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset", 56'h00_00_00_01_01_01_00);
    endtask

    task automatic t_seconds();
        do_load(56'h58_34_12_02_10_06_25);
        tick_once();
        check("R1/R9 sec step", 56'h59_34_12_02_10_06_25);
        tick_once();
        check("R1 sec wrap carries", 56'h00_35_12_02_10_06_25);
        do_load(56'h59_59_09_02_10_06_25);
        tick_once();
        check("R2 minute wrap bcd hour", 56'h00_00_10_02_10_06_25);
        repeat (3) @(negedge clk);
        check("R9 no tick no change", 56'h00_00_10_02_10_06_25);
    endtask

    task automatic t_midnight();
        do_load(56'h59_59_23_07_15_03_21);
        tick_once();
        check("R2/R3 midnight wday wrap", 56'h00_00_00_01_16_03_21);
    endtask

    task automatic t_month_end();
        do_load(56'h59_59_23_03_30_04_21);
        tick_once();
        check("R4 30-day month", 56'h00_00_00_04_01_05_21);
        do_load(56'h59_59_23_03_30_05_21);
        tick_once();
        check("R4 31-day month", 56'h00_00_00_04_31_05_21);
        do_load(56'h59_59_23_05_30_11_21);
        tick_once();
        check("R4 month 11", 56'h00_00_00_06_01_12_21);
    endtask

    task automatic t_february();
        do_load(56'h59_59_23_01_28_02_24);
        tick_once();
        check("R5 leap 24 day 29", 56'h00_00_00_02_29_02_24);
        do_load(56'h59_59_23_01_29_02_24);
        tick_once();
        check("R5 leap 24 end", 56'h00_00_00_02_01_03_24);
        do_load(56'h59_59_23_01_28_02_23);
        tick_once();
        check("R5 common 23", 56'h00_00_00_02_01_03_23);
        do_load(56'h59_59_23_01_28_02_00);
        tick_once();
        check("R5 year 00 leap", 56'h00_00_00_02_29_02_00);
        do_load(56'h59_59_23_01_28_02_10);
        tick_once();
        check("R5 common 10", 56'h00_00_00_02_01_03_10);
        do_load(56'h59_59_23_01_28_02_96);
        tick_once();
        check("R5 leap 96", 56'h00_00_00_02_29_02_96);
    endtask

    task automatic t_year();
        do_load(56'h59_59_23_07_31_12_99);
        tick_once();
        check("R6 year 99 wrap", 56'h00_00_00_01_01_01_00);
        do_load(56'h59_59_23_02_31_12_19);
        tick_once();
        check("R6 year bcd carry", 56'h00_00_00_03_01_01_20);
    endtask

    task automatic t_halt_load();
        do_load(56'h10_20_05_04_12_08_30);
        @(negedge clk);
        halt = 1'b1; tick_en = 1'b1;
        repeat (2) @(negedge clk);
        tick_en = 1'b0;
        check("R7 halt freezes", 56'h10_20_05_04_12_08_30);
        do_load(56'h44_33_22_05_11_07_41);
        check("R8 load while halted", 56'h44_33_22_05_11_07_41);
        halt = 1'b0;
        @(negedge clk);
        ld_v = 56'h05_06_07_01_02_03_04; load = 1'b1; tick_en = 1'b1;
        @(negedge clk);
        load = 1'b0; tick_en = 1'b0;
        check("R8 load beats tick", 56'h05_06_07_01_02_03_04);
        tick_once();
        check("R8 counts from loaded", 56'h06_06_07_01_02_03_04);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seconds();
        t_midnight();
        t_month_end();
        t_february();
        t_year();
        t_halt_load();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule